// File: doc/BRIEF.md
# Load Wait and Stall Length Predictor

This block is a small table, addressed by the program counter of a load, that says two things about that load's next execution: whether it is likely to sit waiting behind an older store whose address is still unknown, and how many cycles that wait is likely to last. A fetch or issue controller can use the wait bit to hold a thread back before it clogs shared queues. It can use the predicted length to release the thread just early enough that its instructions arrive as the stall ends.

Each entry has a sticky wait bit, an 8-bit predicted length and a short history of recent stall lengths with their running sum. The training port reports, for a load that has retired or resolved, whether it stalled and for how long. A policy input chooses how the length field learns: it can keep the largest length seen, copy the latest length, or average the last few lengths with a shift. The table is direct-mapped and has no tags. A clear pulse empties it, so old predictions fade away.

Top module: `ldp_predictor`

## Requirements
- R1: A lookup presented with `lk_valid_i` high produces `lk_valid_o` high exactly one clock later, and `lk_valid_o` is low one clock after any cycle with `lk_valid_i` low.
- R2: The entry index is PC bits [ALIGN_W +: IDX_W] (bits 7:2 with defaults). PCs that agree in those bits share one entry, whatever their other bits.
- R3: A training event with `tr_stall_i` high sets the entry's wait bit. No training event ever clears it.
- R4: A training event with `tr_stall_i` low leaves the entry unchanged: wait bit, length and history.
- R5: With `policy_i` = 0, a stalled training event sets the length to the larger of the stored length and the observed length.
- R6: With `policy_i` = 1, and also with the value 3, a stalled training event sets the length to the observed length.
- R7: With `policy_i` = 2, the length becomes the sum of the last 2^HIST_LOG observed lengths divided by 2^HIST_LOG, rounded down. Slots not yet filled since reset or clear count as zero. The history is updated on every stalled training event, whatever the policy.
- R8: An observed length above 255 is taken as 255 before it is used, so the length never exceeds 255.
- R9: Reset, and a cycle with `clear_i` high, zero every entry. A training event in the same cycle as `clear_i` is dropped. After reset, the lookup outputs read zero.
- R10: A lookup and a training event to the same index in the same cycle return the contents the entry had before that training.
- R11: `lk_wait_o` and `lk_delay_o` keep their values in cycles that follow a cycle with no lookup.
- R12: Any lookup result with a nonzero length also has the wait bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clear_i | input | 1 | Zero every table entry this cycle |
| policy_i | input | 2 | Length learning rule: 0 max, 1 last, 2 average, 3 last |
| lk_valid_i | input | 1 | Lookup request |
| lk_pc_i | input | PC_W | PC of the load being looked up |
| lk_valid_o | output | 1 | Lookup result valid, one cycle after request |
| lk_wait_o | output | 1 | Predicted to wait for an older store |
| lk_delay_o | output | DLY_W | Predicted stall length in cycles |
| tr_valid_i | input | 1 | Training event |
| tr_pc_i | input | PC_W | PC of the trained load |
| tr_stall_i | input | 1 | The load did stall on a store |
| tr_obs_i | input | OBS_W | Observed stall length in cycles |

## Verification
The checker watches four properties on every cycle: the one-cycle lookup latency, zero results right after a clear, the outputs holding when no lookup was issued, and a nonzero length never appearing without the wait bit. The learning rules, saturation, aliasing of PCs that share an index, the dropped training under clear and the old-contents rule for same-cycle read and write depend on what was trained earlier. Only the bench's reference model can show those. It replays each of these scenarios and compares all outputs on every clock.

// File: rtl/ldp_pkg.sv
package ldp_pkg;
  typedef enum logic [1:0] {
    POL_MAX  = 2'd0,
    POL_LAST = 2'd1,
    POL_AVG  = 2'd2,
    POL_ALT  = 2'd3
  } ldp_policy_e;
endpackage

// File: rtl/ldp_index.sv
module ldp_index #(
  parameter int PC_W    = 32,
  parameter int IDX_W   = 6,
  parameter int ALIGN_W = 2
) (
  input  logic [PC_W-1:0]  pc,
  output logic [IDX_W-1:0] idx
);
  // Upper and alignment bits take no part in the index: the table has no tags.
  logic unused_pc_bits;
  assign unused_pc_bits = ^{pc[PC_W-1:ALIGN_W+IDX_W], pc[ALIGN_W-1:0]};
  assign idx = pc[ALIGN_W +: IDX_W];
endmodule

// File: rtl/ldp_delay_calc.sv
module ldp_delay_calc
  import ldp_pkg::*;
#(
  parameter int DLY_W    = 8,
  parameter int OBS_W    = 16,
  parameter int HIST_LOG = 2,
  localparam int HIST_N  = 1 << HIST_LOG,
  localparam int HBITS   = HIST_N * DLY_W,
  localparam int SUM_W   = DLY_W + HIST_LOG
) (
  input  logic [1:0]       policy,
  input  logic [OBS_W-1:0] obs,
  input  logic [DLY_W-1:0] old_dly,
  input  logic [HBITS-1:0] old_hist,
  input  logic [SUM_W-1:0] old_sum,
  output logic [DLY_W-1:0] new_dly,
  output logic [HBITS-1:0] new_hist,
  output logic [SUM_W-1:0] new_sum
);
  localparam logic [DLY_W-1:0] DMAX = {DLY_W{1'b1}};

  logic [DLY_W-1:0] obs_sat;
  logic [DLY_W-1:0] oldest;

  assign obs_sat = (obs > OBS_W'(DMAX)) ? DMAX : obs[DLY_W-1:0];
  assign oldest  = old_hist[HBITS-1 -: DLY_W];

  generate
    if (HIST_N == 1) begin : g_single
      assign new_hist = obs_sat;
    end else begin : g_shift
      assign new_hist = {old_hist[HBITS-DLY_W-1:0], obs_sat};
    end
  endgenerate

  // Running sum: drop the oldest sample, add the newest.
  assign new_sum = old_sum - SUM_W'(oldest) + SUM_W'(obs_sat);

  always_comb begin
    unique case (ldp_policy_e'(policy))
      POL_MAX:  new_dly = (old_dly > obs_sat) ? old_dly : obs_sat;
      POL_AVG:  new_dly = new_sum[HIST_LOG +: DLY_W];
      default:  new_dly = obs_sat;
    endcase
  end
endmodule

// File: rtl/ldp_entry.sv
module ldp_entry #(
  parameter int DLY_W    = 8,
  parameter int HIST_LOG = 2,
  localparam int HBITS   = (1 << HIST_LOG) * DLY_W,
  localparam int SUM_W   = DLY_W + HIST_LOG
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             we,
  input  logic [DLY_W-1:0] wr_dly,
  input  logic [HBITS-1:0] wr_hist,
  input  logic [SUM_W-1:0] wr_sum,
  output logic             wait_q,
  output logic [DLY_W-1:0] dly_q,
  output logic [HBITS-1:0] hist_q,
  output logic [SUM_W-1:0] sum_q
);
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wait_q <= 1'b0;
      dly_q  <= '0;
      hist_q <= '0;
      sum_q  <= '0;
    end else if (we) begin
      wait_q <= 1'b1;
      dly_q  <= wr_dly;
      hist_q <= wr_hist;
      sum_q  <= wr_sum;
    end
  end
endmodule

// File: rtl/ldp_predictor.sv
module ldp_predictor #(
  parameter int PC_W     = 32,
  parameter int IDX_W    = 6,
  parameter int ALIGN_W  = 2,
  parameter int DLY_W    = 8,
  parameter int OBS_W    = 16,
  parameter int HIST_LOG = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear_i,
  input  logic [1:0]       policy_i,
  input  logic             lk_valid_i,
  input  logic [PC_W-1:0]  lk_pc_i,
  output logic             lk_valid_o,
  output logic             lk_wait_o,
  output logic [DLY_W-1:0] lk_delay_o,
  input  logic             tr_valid_i,
  input  logic [PC_W-1:0]  tr_pc_i,
  input  logic             tr_stall_i,
  input  logic [OBS_W-1:0] tr_obs_i
);
  localparam int ENTRIES = 1 << IDX_W;
  localparam int HBITS   = (1 << HIST_LOG) * DLY_W;
  localparam int SUM_W   = DLY_W + HIST_LOG;

  logic [IDX_W-1:0] lk_idx, tr_idx;
  logic             wait_a [ENTRIES];
  logic [DLY_W-1:0] dly_a  [ENTRIES];
  logic [HBITS-1:0] hist_a [ENTRIES];
  logic [SUM_W-1:0] sum_a  [ENTRIES];
  logic [DLY_W-1:0] nd;
  logic [HBITS-1:0] nh;
  logic [SUM_W-1:0] ns;
  logic             train_en;

  ldp_index #(.PC_W(PC_W), .IDX_W(IDX_W), .ALIGN_W(ALIGN_W)) u_lk_idx (
    .pc(lk_pc_i), .idx(lk_idx));
  ldp_index #(.PC_W(PC_W), .IDX_W(IDX_W), .ALIGN_W(ALIGN_W)) u_tr_idx (
    .pc(tr_pc_i), .idx(tr_idx));

  ldp_delay_calc #(.DLY_W(DLY_W), .OBS_W(OBS_W), .HIST_LOG(HIST_LOG)) u_calc (
    .policy  (policy_i),
    .obs     (tr_obs_i),
    .old_dly (dly_a[tr_idx]),
    .old_hist(hist_a[tr_idx]),
    .old_sum (sum_a[tr_idx]),
    .new_dly (nd),
    .new_hist(nh),
    .new_sum (ns)
  );

  // Only a stall trains; clear has priority over training.
  assign train_en = tr_valid_i && tr_stall_i && !clear_i;

  generate
    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
      ldp_entry #(.DLY_W(DLY_W), .HIST_LOG(HIST_LOG)) u_ent (
        .clk    (clk),
        .rst    (rst),
        .clr    (clear_i),
        .we     (train_en && (tr_idx == IDX_W'(g))),
        .wr_dly (nd),
        .wr_hist(nh),
        .wr_sum (ns),
        .wait_q (wait_a[g]),
        .dly_q  (dly_a[g]),
        .hist_q (hist_a[g]),
        .sum_q  (sum_a[g])
      );
    end
  endgenerate

  // Registered lookup: reads pre-edge contents, so same-cycle training is not visible.
  always_ff @(posedge clk) begin
    if (rst) begin
      lk_valid_o <= 1'b0;
      lk_wait_o  <= 1'b0;
      lk_delay_o <= '0;
    end else begin
      lk_valid_o <= lk_valid_i;
      if (lk_valid_i) begin
        lk_wait_o  <= wait_a[lk_idx];
        lk_delay_o <= dly_a[lk_idx];
      end
    end
  end
endmodule

// File: rtl/ldp_predictor_chk.sv
module ldp_predictor_chk #(
  parameter int DLY_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             clear_i,
  input logic             lk_valid_i,
  input logic             lk_valid_o,
  input logic             lk_wait_o,
  input logic [DLY_W-1:0] lk_delay_o
);
  logic clear_q;
  always_ff @(posedge clk) begin
    if (rst) clear_q <= 1'b0;
    else     clear_q <= clear_i;
  end

  p_lookup_lat_r1: assert property (@(posedge clk) disable iff (rst)
    lk_valid_i |=> lk_valid_o);
  p_no_spurious_r1: assert property (@(posedge clk) disable iff (rst)
    !lk_valid_i |=> !lk_valid_o);
  p_cleared_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (clear_q && lk_valid_i) |=> (!lk_wait_o && lk_delay_o == '0));
  p_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !lk_valid_i |=> ($stable(lk_wait_o) && $stable(lk_delay_o)));
  p_wait_covers_delay_r12: assert property (@(posedge clk) disable iff (rst)
    (lk_valid_o && lk_delay_o != '0) |-> lk_wait_o);
endmodule

bind ldp_predictor ldp_predictor_chk #(.DLY_W(DLY_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .clear_i   (clear_i),
  .lk_valid_i(lk_valid_i),
  .lk_valid_o(lk_valid_o),
  .lk_wait_o (lk_wait_o),
  .lk_delay_o(lk_delay_o)
);

// File: tb/ldp_predictor_tb.sv
`timescale 1ns/1ps
module ldp_predictor_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        clear_i = 1'b0;
  logic [1:0]  policy_i = 2'd0;
  logic        lk_valid_i = 1'b0;
  logic [31:0] lk_pc_i = '0;
  logic        lk_valid_o, lk_wait_o;
  logic [7:0]  lk_delay_o;
  logic        tr_valid_i = 1'b0;
  logic [31:0] tr_pc_i = '0;
  logic        tr_stall_i = 1'b0;
  logic [15:0] tr_obs_i = '0;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  // reference model state
  int m_wait [64];
  int m_dly  [64];
  int m_hist [64][4];
  int e_valid = 0, e_wait = 0, e_dly = 0;

  always #2 clk = ~clk;

  ldp_predictor u_dut (
    .clk(clk), .rst(rst), .clear_i(clear_i), .policy_i(policy_i),
    .lk_valid_i(lk_valid_i), .lk_pc_i(lk_pc_i),
    .lk_valid_o(lk_valid_o), .lk_wait_o(lk_wait_o), .lk_delay_o(lk_delay_o),
    .tr_valid_i(tr_valid_i), .tr_pc_i(tr_pc_i), .tr_stall_i(tr_stall_i),
    .tr_obs_i(tr_obs_i)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      total++; bad++;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected <=20000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic logic [31:0] pc_of(int idx, int hi, int lo);
    return (32'(hi) << 8) | (32'(idx & 63) << 2) | 32'(lo & 3);
  endfunction

  task automatic model_step();
    int li, ti, s, sum;
    if (rst) begin
      for (int i = 0; i < 64; i++) begin
        m_wait[i] = 0; m_dly[i] = 0;
        for (int k = 0; k < 4; k++) m_hist[i][k] = 0;
      end
      e_valid = 0; e_wait = 0; e_dly = 0;
      return;
    end
    li = int'(lk_pc_i[7:2]);
    e_valid = lk_valid_i ? 1 : 0;
    if (lk_valid_i) begin e_wait = m_wait[li]; e_dly = m_dly[li]; end
    if (clear_i) begin
      for (int i = 0; i < 64; i++) begin
        m_wait[i] = 0; m_dly[i] = 0;
        for (int k = 0; k < 4; k++) m_hist[i][k] = 0;
      end
    end else if (tr_valid_i && tr_stall_i) begin
      ti = int'(tr_pc_i[7:2]);
      s = (int'(tr_obs_i) > 255) ? 255 : int'(tr_obs_i);
      for (int k = 3; k > 0; k--) m_hist[ti][k] = m_hist[ti][k-1];
      m_hist[ti][0] = s;
      sum = 0;
      for (int k = 0; k < 4; k++) sum += m_hist[ti][k];
      case (policy_i)
        2'd0: m_dly[ti] = (m_dly[ti] > s) ? m_dly[ti] : s;
        2'd2: m_dly[ti] = sum / 4;
        default: m_dly[ti] = s;
      endcase
      m_wait[ti] = 1;
    end
  endtask

  task automatic compare(string tag);
    total++;
    if (int'(lk_valid_o) != e_valid || int'(lk_wait_o) != e_wait || int'(lk_delay_o) != e_dly) begin
      bad++;
      $display("FAIL %s: actual valid=%0d wait=%0d delay=%0d expected valid=%0d wait=%0d delay=%0d",
               tag, lk_valid_o, lk_wait_o, lk_delay_o, e_valid, e_wait, e_dly);
    end
  endtask

  task automatic cyc(string tag, bit lv, logic [31:0] lpc, bit tv, logic [31:0] tpc,
                     bit ts, int obs, bit clr, logic [1:0] pol);
    lk_valid_i = lv; lk_pc_i = lpc;
    tr_valid_i = tv; tr_pc_i = tpc; tr_stall_i = ts; tr_obs_i = 16'(obs);
    clear_i = clr; policy_i = pol;
    @(posedge clk); #1;
    model_step();
    compare(tag);
  endtask

  task automatic train(string tag, int idx, int obs, logic [1:0] pol);
    cyc(tag, 0, '0, 1, pc_of(idx, 0, 0), 1, obs, 0, pol);
  endtask

  task automatic look(string tag, logic [31:0] pc);
    cyc(tag, 1, pc, 0, '0, 0, 0, 0, 2'd0);
    cyc(tag, 0, '0, 0, '0, 0, 0, 0, 2'd0);
  endtask

  initial begin
    // R9: reset state
    for (int i = 0; i < 3; i++) cyc("R9_reset", 0, '0, 0, '0, 0, 0, 0, 2'd0);
    rst = 1'b0;
    look("R9_untrained", pc_of(5, 0, 0));
    // R3 / R6: last-value policy
    train("R3", 5, 20, 2'd1);
    look("R3_R6", pc_of(5, 0, 0));
    train("R6", 5, 7, 2'd1);
    look("R6", pc_of(5, 0, 0));
    train("R6_alt", 5, 11, 2'd3);
    look("R6_alt", pc_of(5, 0, 0));
    // R5: maximum policy
    train("R5", 6, 10, 2'd0);
    train("R5", 6, 30, 2'd0);
    train("R5", 6, 12, 2'd0);
    look("R5", pc_of(6, 0, 0));
    // R7: average policy
    train("R7", 7, 40, 2'd2);
    look("R7_first", pc_of(7, 0, 0));
    train("R7", 7, 40, 2'd2);
    look("R7_second", pc_of(7, 0, 0));
    train("R7", 7, 40, 2'd2);
    train("R7", 7, 40, 2'd2);
    look("R7_full", pc_of(7, 0, 0));
    train("R7", 7, 8, 2'd2);
    look("R7_slide", pc_of(7, 0, 0));
    // R8: saturation
    train("R8", 8, 1000, 2'd1);
    look("R8_last", pc_of(8, 0, 0));
    for (int i = 0; i < 4; i++) train("R8", 9, 60000, 2'd2);
    look("R8_avg", pc_of(9, 0, 0));
    // R4: no-stall training ignored
    cyc("R4", 0, '0, 1, pc_of(5, 0, 0), 0, 99, 0, 2'd1);
    look("R4", pc_of(5, 0, 0));
    cyc("R4", 0, '0, 1, pc_of(7, 0, 0), 0, 200, 0, 2'd2);
    train("R4_hist", 7, 0, 2'd2);
    look("R4_hist", pc_of(7, 0, 0));
    // R2: aliasing through upper and alignment bits
    look("R2_alias_hi", pc_of(5, 123, 0));
    look("R2_alias_lo", pc_of(5, 0, 3));
    look("R2_neighbor", pc_of(4, 0, 0));
    // R10: same-cycle read and write
    cyc("R10", 1, pc_of(6, 0, 0), 1, pc_of(6, 9, 0), 1, 77, 0, 2'd1);
    look("R10_after", pc_of(6, 0, 0));
    // R11: hold when idle
    for (int i = 0; i < 3; i++) cyc("R11_hold", 0, '0, 0, '0, 0, 0, 0, 2'd0);
    // sweep all entries
    for (int i = 0; i < 64; i++) train("R2_sweep", i, i * 3 + 1, 2'd1);
    for (int i = 0; i < 64; i++) cyc("R2_sweep", 1, pc_of(i, i, 0), 0, '0, 0, 0, 0, 2'd0);
    // R9: clear beats simultaneous training
    cyc("R9_clear", 1, pc_of(6, 0, 0), 1, pc_of(6, 0, 0), 1, 50, 1, 2'd1);
    look("R9_cleared", pc_of(6, 0, 0));
    look("R9_cleared", pc_of(8, 0, 0));
    train("R7_restart", 7, 100, 2'd2);
    look("R7_restart", pc_of(7, 0, 0));
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule